// File: doc/BRIEF.md
# MDIO Tunnelled 32-bit Register Access Sequencer

This block lets a controller reach the 32-bit registers of a device that is only reachable through 16-bit MDIO accesses. A request carries an 18-bit byte address, a read/write flag, 32 bits of write data and a mapping-mode flag. The block turns it into three downstream MDIO transactions: first a page-select write, then two 16-bit accesses, one for each half of the word. Read halves are reassembled into one 32-bit word. A one-cycle done pulse ends each request, together with an error flag.

The downstream side is a request/complete handshake to an MDIO master that drives the serial lines. The block raises `mdio_req_o` for one cycle with PHY, register, direction and data. It then waits for `mdio_done_i` before it issues anything else. The block serves one request at a time.

Top module: `mdio_reg_tunnel`

## Requirements
- R1: The first transaction of every request is a write to PHY `PAGE_PHY` (default 0x18), register `PAGE_REG` (default 0x00). Its data is the page number, which is the byte address shifted right by 9 and zero-extended to 16 bits. In wide mode (`req_wide_i`=1) the page is limited to 9 bits.
- R2: In default mode (`req_wide_i`=0) both data halves use PHY 0x10 | address[8:6]. The low half uses register {address[5:2],0} and the high half uses register {address[5:2],1}.
- R3: In wide mode, let w = {address[17:2],0}. The low half uses PHY 0x10 | w[7:5] and register w[4:0]. The high half uses the same two formulas applied to w+1.
- R4: A read fetches the low half first and the high half second. The result on `rsp_rdata_o` is {high, low}.
- R5: A write sends `req_wdata_i[31:16]` to the high-half target first, then `req_wdata_i[15:0]` to the low-half target.
- R6: A write in default mode to byte address 0x98 sends the low half first and the high half second. In wide mode, and for reads, address 0x98 keeps the normal order.
- R7: `mdio_req_o` is a one-cycle pulse. The next one is raised in the cycle after the previous transaction's `mdio_done_i` is sampled, and never while a transaction is outstanding.
- R8: `rsp_done_o` is a one-cycle pulse. It is raised in the cycle after the `mdio_done_i` of the last transaction, once per request, with `rsp_err_o`=0 when no error was reported.
- R9: If `mdio_done_i` arrives with `mdio_err_i`=1, no further transaction is issued. `rsp_done_o` and `rsp_err_o` are both 1 in the next cycle.
- R10: `req_ready_o` falls in the cycle after a request is accepted and stays low until `rsp_done_o`. A request presented while it is low is ignored.
- R11: After reset, `req_ready_o`=1 and `mdio_req_o`, `rsp_done_o` and `rsp_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present; accepted when ready is high |
| req_ready_o | output | 1 | Idle, can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wide_i | input | 1 | 1 = wide-page mapping, 0 = default mapping |
| req_addr_i | input | 18 | Register byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_err_o | output | 1 | Downstream error, valid with done |
| rsp_rdata_o | output | 32 | Assembled read data |
| mdio_req_o | output | 1 | One-cycle downstream transaction start |
| mdio_write_o | output | 1 | Downstream direction, 1 = write |
| mdio_phy_o | output | 5 | Downstream PHY address |
| mdio_reg_o | output | 5 | Downstream register number |
| mdio_wdata_o | output | 16 | Downstream write data |
| mdio_done_i | input | 1 | Downstream transaction complete |
| mdio_err_i | input | 1 | Downstream transaction failed, valid with done |
| mdio_rdata_i | input | 16 | Downstream read data, valid with done |

## Verification
The page write appears on `mdio_req_o` one cycle after the accepting edge. Each later transaction appears one cycle after the edge that samples the previous `mdio_done_i`. `rsp_done_o`, `rsp_err_o` and the final read data appear one cycle after the last sampled done. The bench's downstream model answers after a chosen latency and logs every transaction. All outputs are sampled 1 ns after the falling edge. Each completion is checked to follow, at the next sample, a sample in which `mdio_done_i` was high. A few further samples confirm that nothing else is issued.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } mrt_state_e;

  typedef struct packed {
    logic [4:0] phy;
    logic [4:0] regn;
  } mrt_target_t;
endpackage

// File: rtl/mrt_addr_map.sv
module mrt_addr_map
  import mrt_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int PAGE_W = 16,
  parameter int WIDE_PAGE_W = 9
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wide_i,
  output logic [PAGE_W-1:0] page_o,
  output mrt_target_t       lo_o,
  output mrt_target_t       hi_o
);
  localparam int WIDX_W = ADDR_W - 1;
  localparam logic [PAGE_W-1:0] WIDE_MASK = PAGE_W'((1 << WIDE_PAGE_W) - 1);

  logic [WIDX_W-1:0] w0, w1;
  logic [PAGE_W-1:0] page_full;

  assign w0        = {addr_i[ADDR_W-1:2], 1'b0};
  assign w1        = w0 + {{(WIDX_W-1){1'b0}}, 1'b1};
  assign page_full = PAGE_W'(addr_i >> 9);

  always_comb begin
    if (wide_i) begin
      page_o     = page_full & WIDE_MASK;
      lo_o.phy   = {2'b10, w0[7:5]};
      lo_o.regn  = w0[4:0];
      hi_o.phy   = {2'b10, w1[7:5]};
      hi_o.regn  = w1[4:0];
    end else begin
      page_o     = page_full;
      lo_o.phy   = {2'b10, addr_i[8:6]};
      lo_o.regn  = {addr_i[5:2], 1'b0};
      hi_o.phy   = {2'b10, addr_i[8:6]};
      hi_o.regn  = {addr_i[5:2], 1'b1};
    end
  end
endmodule

// File: rtl/mrt_seq.sv
module mrt_seq
  import mrt_pkg::*;
#(
  parameter int          ADDR_W    = 18,
  parameter int          DATA_W    = 32,
  parameter logic [4:0]  PAGE_PHY  = 5'h18,
  parameter logic [4:0]  PAGE_REG  = 5'h00,
  parameter logic [ADDR_W-1:0] SWAP_ADDR = ADDR_W'(18'h98)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_wide_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_done_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] map_addr_o,
  output logic              map_wide_o,
  input  logic [DATA_W/2-1:0] map_page_i,
  input  mrt_target_t       map_lo_i,
  input  mrt_target_t       map_hi_i,
  output logic              mdio_req_o,
  output logic              mdio_write_o,
  output logic [4:0]        mdio_phy_o,
  output logic [4:0]        mdio_reg_o,
  output logic [DATA_W/2-1:0] mdio_wdata_o,
  input  logic              mdio_done_i,
  input  logic              mdio_err_i,
  input  logic [DATA_W/2-1:0] mdio_rdata_i
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [1:0] STEP_PAGE = 2'd0;
  localparam logic [1:0] STEP_LAST = 2'd2;

  mrt_state_e          state_q;
  logic [1:0]          step_q;
  logic                write_q, wide_q, done_q, err_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q, rdata_q;
  logic                first_hi, cur_hi;
  mrt_target_t         cur_tgt;

  // write order swaps for the special address in default mode only
  assign first_hi = write_q && !(!wide_q && (addr_q == SWAP_ADDR));
  assign cur_hi   = (step_q == 2'd1) ? first_hi : !first_hi;
  assign cur_tgt  = cur_hi ? map_hi_i : map_lo_i;

  assign map_addr_o   = addr_q;
  assign map_wide_o   = wide_q;
  assign req_ready_o  = (state_q == ST_IDLE);
  assign mdio_req_o   = (state_q == ST_ISSUE);
  assign mdio_write_o = (step_q == STEP_PAGE) || write_q;
  assign mdio_phy_o   = (step_q == STEP_PAGE) ? PAGE_PHY : cur_tgt.phy;
  assign mdio_reg_o   = (step_q == STEP_PAGE) ? PAGE_REG : cur_tgt.regn;
  assign mdio_wdata_o = (step_q == STEP_PAGE) ? map_page_i :
                        (cur_hi ? wdata_q[DATA_W-1:HALF_W] : wdata_q[HALF_W-1:0]);
  assign rsp_done_o   = done_q;
  assign rsp_err_o    = err_q;
  assign rsp_rdata_o  = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= STEP_PAGE;
      write_q <= 1'b0;
      wide_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          write_q <= req_write_i;
          wide_q  <= req_wide_i;
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          rdata_q <= '0;
          step_q  <= STEP_PAGE;
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (mdio_done_i) begin
          if (!write_q && step_q != STEP_PAGE) begin
            if (cur_hi) rdata_q[DATA_W-1:HALF_W] <= mdio_rdata_i;
            else        rdata_q[HALF_W-1:0]      <= mdio_rdata_i;
          end
          if (mdio_err_i || step_q == STEP_LAST) begin
            done_q  <= 1'b1;
            err_q   <= mdio_err_i;
            state_q <= ST_IDLE;
          end else begin
            step_q  <= step_q + 2'd1;
            state_q <= ST_ISSUE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_req_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_req_o |=> !mdio_req_o);
  assert_hold_while_outstanding_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !mdio_done_i) |=> !mdio_req_o);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);
  assert_err_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && mdio_done_i && mdio_err_i) |=> (rsp_done_o && rsp_err_o && !mdio_req_o));
  assert_busy_after_accept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
endmodule

// File: rtl/mdio_reg_tunnel.sv
module mdio_reg_tunnel
  import mrt_pkg::*;
#(
  parameter int         ADDR_W    = 18,
  parameter int         DATA_W    = 32,
  parameter logic [4:0] PAGE_PHY  = 5'h18,
  parameter logic [4:0] PAGE_REG  = 5'h00,
  parameter logic [ADDR_W-1:0] SWAP_ADDR = ADDR_W'(18'h98)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_write_i,
  input  logic                req_wide_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                rsp_done_o,
  output logic                rsp_err_o,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  output logic                mdio_req_o,
  output logic                mdio_write_o,
  output logic [4:0]          mdio_phy_o,
  output logic [4:0]          mdio_reg_o,
  output logic [DATA_W/2-1:0] mdio_wdata_o,
  input  logic                mdio_done_i,
  input  logic                mdio_err_i,
  input  logic [DATA_W/2-1:0] mdio_rdata_i
);
  localparam int HALF_W = DATA_W / 2;

  logic [ADDR_W-1:0] map_addr;
  logic              map_wide;
  logic [HALF_W-1:0] map_page;
  mrt_target_t       map_lo, map_hi;

  mrt_addr_map #(.ADDR_W(ADDR_W), .PAGE_W(HALF_W)) u_map (
    .addr_i (map_addr),
    .wide_i (map_wide),
    .page_o (map_page),
    .lo_o   (map_lo),
    .hi_o   (map_hi)
  );

  mrt_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PAGE_PHY(PAGE_PHY), .PAGE_REG(PAGE_REG), .SWAP_ADDR(SWAP_ADDR)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .req_write_i  (req_write_i),
    .req_wide_i   (req_wide_i),
    .req_addr_i   (req_addr_i),
    .req_wdata_i  (req_wdata_i),
    .rsp_done_o   (rsp_done_o),
    .rsp_err_o    (rsp_err_o),
    .rsp_rdata_o  (rsp_rdata_o),
    .map_addr_o   (map_addr),
    .map_wide_o   (map_wide),
    .map_page_i   (map_page),
    .map_lo_i     (map_lo),
    .map_hi_i     (map_hi),
    .mdio_req_o   (mdio_req_o),
    .mdio_write_o (mdio_write_o),
    .mdio_phy_o   (mdio_phy_o),
    .mdio_reg_o   (mdio_reg_o),
    .mdio_wdata_o (mdio_wdata_o),
    .mdio_done_i  (mdio_done_i),
    .mdio_err_i   (mdio_err_i),
    .mdio_rdata_i (mdio_rdata_i)
  );

  assert_page_first_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=>
      (mdio_req_o && mdio_write_o && mdio_phy_o == PAGE_PHY && mdio_reg_o == PAGE_REG));
endmodule

// File: tb/mdio_reg_tunnel_bench.sv
`timescale 1ns/1ps
module mdio_reg_tunnel_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0, req_wide_i = 1'b0;
  logic [17:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic        req_ready_o, rsp_done_o, rsp_err_o;
  logic [31:0] rsp_rdata_o;
  logic        mdio_req_o, mdio_write_o;
  logic [4:0]  mdio_phy_o, mdio_reg_o;
  logic [15:0] mdio_wdata_o;
  logic        mdio_done_i = 1'b0, mdio_err_i = 1'b0;
  logic [15:0] mdio_rdata_i = '0;

  always #4 clk_i = ~clk_i;

  mdio_reg_tunnel u_mdio_reg_tunnel (.*);

  int n_chk = 0, n_fail = 0;
  int lg_n = 0, overlap = 0, resp_lat = 2, err_at = -1;
  int lg_wr [256], lg_phy [256], lg_reg [256], lg_wd [256];

  function automatic logic [15:0] resp16(input int phy, input int rg);
    return {3'b101, 5'(phy), 5'(rg), 3'b011};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  // downstream MDIO master model
  initial begin
    forever begin
      @(negedge clk_i);
      mdio_done_i = 1'b0;
      mdio_err_i  = 1'b0;
      if (mdio_req_o) begin
        int idx;
        idx = lg_n;
        lg_wr[idx]  = int'(mdio_write_o);
        lg_phy[idx] = int'(mdio_phy_o);
        lg_reg[idx] = int'(mdio_reg_o);
        lg_wd[idx]  = int'(mdio_wdata_o);
        lg_n++;
        for (int k = 0; k < resp_lat; k++) begin
          @(negedge clk_i);
          if (mdio_req_o) overlap++;
        end
        mdio_rdata_i = resp16(lg_phy[idx], lg_reg[idx]);
        mdio_err_i   = (idx == err_at);
        mdio_done_i  = 1'b1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    summary();
  end

  task automatic run_op(input bit wr, input bit wide, input int addr, input int wd,
                        input int lat, input int err_k, input bit stray, input string tag);
    int page, w0, w1, lo_phy, lo_reg, hi_phy, hi_reg, base, ntx, n, rbad;
    bit got, prevdone, hi_first;
    int e_wr[3], e_phy[3], e_reg[3], e_wd[3];
    page = wide ? ((addr >> 9) & 'h1FF) : (addr >> 9);
    if (wide) begin
      w0 = (addr & ~3) >> 1; w1 = w0 + 1;
      lo_phy = 'h10 | ((w0 >> 5) & 7); lo_reg = w0 & 'h1F;
      hi_phy = 'h10 | ((w1 >> 5) & 7); hi_reg = w1 & 'h1F;
    end else begin
      lo_phy = 'h10 | ((addr >> 6) & 7); lo_reg = (addr >> 1) & 'h1E;
      hi_phy = lo_phy;                   hi_reg = lo_reg | 1;
    end
    hi_first = wr && !(!wide && addr == 'h98);
    e_wr[0] = 1; e_phy[0] = 'h18; e_reg[0] = 0; e_wd[0] = page;
    for (int i = 1; i < 3; i++) begin
      bit h;
      h = (i == 1) ? hi_first : !hi_first;
      e_wr[i]  = int'(wr);
      e_phy[i] = h ? hi_phy : lo_phy;
      e_reg[i] = h ? hi_reg : lo_reg;
      e_wd[i]  = wr ? (h ? ((wd >> 16) & 'hFFFF) : (wd & 'hFFFF)) : -1;
    end
    base = lg_n;
    resp_lat = lat;
    err_at = (err_k >= 0) ? base + err_k : -1;
    ntx = (err_k >= 0) ? err_k + 1 : 3;

    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = wr; req_wide_i = wide;
    req_addr_i = 18'(addr); req_wdata_i = wd;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    n = 0; got = 0; prevdone = 0; rbad = 0;
    while (n < 400) begin
      @(negedge clk_i); #1;
      if (stray && n == 3) begin
        req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = 18'h01234; req_wide_i = 1'b0;
      end else req_valid_i = 1'b0;
      if (rsp_done_o) begin got = 1; break; end
      if (req_ready_o) rbad++;
      prevdone = mdio_done_i;
      n++;
    end
    req_valid_i = 1'b0;
    chk(got, {tag, " R8 done seen"}, got, 1);
    chk(prevdone, {tag, " R8 done one cycle after last mdio done"}, prevdone, 1);
    chk(rbad == 0, {tag, " R10 ready low while busy"}, rbad, 0);
    chk(req_ready_o, {tag, " R10 ready with done"}, req_ready_o, 1);
    chk(rsp_err_o == (err_k >= 0), {tag, " R9 err flag"}, rsp_err_o, (err_k >= 0));
    chk(lg_n - base == ntx, {tag, " R9 transaction count"}, lg_n - base, ntx);
    for (int i = 0; i < ntx && i < lg_n - base; i++) begin
      string rq;
      rq = (i == 0) ? " R1" : (wide ? " R3" : " R2");
      chk(lg_wr[base+i] == e_wr[i], {tag, rq, " dir"}, lg_wr[base+i], e_wr[i]);
      chk(lg_phy[base+i] == e_phy[i], {tag, rq, " phy"}, lg_phy[base+i], e_phy[i]);
      chk(lg_reg[base+i] == e_reg[i], {tag, rq, (i > 0 ? (wr ? " R5 R6" : " R4") : ""), " reg"},
          lg_reg[base+i], e_reg[i]);
      if (e_wd[i] >= 0)
        chk(lg_wd[base+i] == e_wd[i], {tag, rq, " wdata R5"}, lg_wd[base+i], e_wd[i]);
    end
    if (!wr && err_k < 0)
      chk(rsp_rdata_o == {resp16(hi_phy, hi_reg), resp16(lo_phy, lo_reg)},
          {tag, " R4 rdata"}, rsp_rdata_o, {resp16(hi_phy, hi_reg), resp16(lo_phy, lo_reg)});
    @(negedge clk_i); #1;
    chk(!rsp_done_o, {tag, " R8 done single cycle"}, rsp_done_o, 0);
    repeat (4) @(negedge clk_i);
    #1;
    chk(lg_n - base == ntx, {tag, " R10 nothing issued afterwards"}, lg_n - base, ntx);
    chk(!rsp_done_o, {tag, " R10 no extra done"}, rsp_done_o, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk(req_ready_o, "R11 ready", req_ready_o, 1);
    chk(!mdio_req_o, "R11 mdio_req", mdio_req_o, 0);
    chk(!rsp_done_o, "R11 done", rsp_done_o, 0);
    chk(!rsp_err_o, "R11 err", rsp_err_o, 0);
  endtask

  task automatic t_default_map();
    run_op(1'b0, 1'b0, 'h2A674, 0, 2, -1, 1'b0, "dflt_rd_a");
    run_op(1'b0, 1'b0, 'h001C8, 0, 1, -1, 1'b0, "dflt_rd_b");
    run_op(1'b1, 1'b0, 'h3FE3C, 'hDEADBEEF, 3, -1, 1'b0, "dflt_wr");
  endtask

  task automatic t_wide_map();
    run_op(1'b0, 1'b1, 'h3FFFC, 0, 2, -1, 1'b0, "wide_rd_a");
    run_op(1'b0, 1'b1, 'h2A5E4, 0, 5, -1, 1'b0, "wide_rd_b");
    run_op(1'b1, 1'b1, 'h101FC, 'h12345678, 1, -1, 1'b0, "wide_wr");
  endtask

  task automatic t_swap_addr();
    run_op(1'b1, 1'b0, 'h98, 'hA5A55A5A, 2, -1, 1'b0, "R6_dflt_wr98");
    run_op(1'b1, 1'b1, 'h98, 'h0F0FF0F0, 2, -1, 1'b0, "R6_wide_wr98");
    run_op(1'b0, 1'b0, 'h98, 0, 2, -1, 1'b0, "R6_dflt_rd98");
    run_op(1'b1, 1'b0, 'h9C, 'hCAFE0001, 2, -1, 1'b0, "R6_dflt_wr9c");
  endtask

  task automatic t_error();
    run_op(1'b1, 1'b0, 'h00400, 'h11112222, 2, 0, 1'b0, "R9_err_page");
    run_op(1'b0, 1'b1, 'h12340, 0, 2, 1, 1'b0, "R9_err_first");
    run_op(1'b1, 1'b0, 'h00044, 'h33334444, 1, 2, 1'b0, "R9_err_last");
  endtask

  task automatic t_busy();
    run_op(1'b0, 1'b0, 'h0A0A8, 0, 4, -1, 1'b1, "R10_stray_req");
    chk(overlap == 0, "R7 no transaction while outstanding", overlap, 0);
  endtask

  initial begin
    t_reset();
    t_default_map();
    t_wide_map();
    t_swap_addr();
    t_error();
    t_busy();
    summary();
  end
endmodule